// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit sits beside the decode stage of a vector-capable core. When an instruction carries a 12-bit length-control field, the unit works out new values for a local maximum vector length and a local current vector length, and it stores them. The new current length can also be returned to a scalar destination register. An all-zero field leaves the local state alone, so the global length settings stay in force for that instruction.

The field has five parts. Bit 11 picks either loop mode or a one-off setting of the limits. Bit 0 picks the sub-mode. Bits 5:1 hold a 5-bit immediate or a source register index. Bits 10:6 hold the destination register index. In register-source mode the unit drives a read address from bits 5:1 at once and takes the scalar read data in the same cycle. If an instruction uses a sub-mode the implementation does not support, or names x0 as the length source, the unit raises a one-cycle illegal-instruction pulse and changes nothing.

Top module: `vlcfg_unit`

## Requirements
- R1: After reset, the maximum and current lengths both read 1, and neither the write-back strobe nor the illegal flag is set.
- R2: A strobed field of all zeros changes no state, requests no write-back and raises no illegal flag, whatever the option input is.
- R3: When bit 11 = 0 and bit 0 = 0 and the field is nonzero, the current length becomes the smaller of (bits 5:1 + 1) and the present maximum. The maximum does not change.
- R4: When bit 11 = 0 and bit 0 = 1, the read address equals bits 5:1 in the same cycle. The current length becomes the read data clamped to the present maximum, and a read value of zero gives a length of 1. The maximum does not change.
- R5: When bit 11 = 0, bit 0 = 1 and bits 5:1 = 0, the illegal flag is raised and no state changes.
- R6: When bit 11 = 1 and bit 0 = 0, both the maximum and the current length become bits 5:1 + 1.
- R7: When bit 11 = 1 and bit 0 = 1, the maximum becomes bits 5:1 + 1. The current length keeps its value, unless that value is larger than the new maximum, in which case it drops to the new maximum.
- R8: After every legal, nonzero field whose bits 10:6 are not zero, the write-back strobe is high for one cycle. It carries bits 10:6 as the index and the new current length as the data. A destination of 0 gives no strobe.
- R9: When the option input is 0, any nonzero field raises the illegal flag, changes no state and requests no write-back.
- R10: State, write-back and illegal outputs change on the clock edge that samples the strobe. Each of these pulses lasts exactly one cycle.
- R11: At all times, 1 <= current length <= maximum length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Strobe: the length-control field is present |
| cfg_field | input | 12 | Length-control field |
| opt_en | input | 1 | 1 when the implementation supports a nonzero field |
| rs_idx | output | 5 | Scalar read-port address (bits 5:1 of the field) |
| rs_rdata | input | XLEN | Scalar read-port data |
| max_len | output | LEN_W | Local maximum vector length |
| cur_len | output | LEN_W | Local current vector length |
| wb_valid | output | 1 | Write-back request pulse |
| wb_idx | output | 5 | Write-back destination register index |
| wb_data | output | LEN_W | Write-back length value |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The assertions check the following on every cycle:
- the length ordering invariant holds;
- a zero field or an illegal field leaves the state untouched;
- the maximum is stable in loop mode;
- the limits become equal after a one-off setting;
- the current length never grows in max-only mode;
- no write-back targets x0;
- write-back and illegal never occur together.

Only the bench scenarios show the exact values:
- the immediate-plus-one mapping across every immediate;
- clamping against many maximum settings;
- truncation as the maximum shrinks step by step;
- the zero and over-wide register values;
- the one-cycle timing and width of every pulse.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

    localparam int FIELD_W   = 12;
    localparam int REG_IDX_W = 5;

    // Field layout; bit order is fixed by the instruction encoding.
    typedef struct packed {
        logic                 one_off;   // bit 11
        logic [REG_IDX_W-1:0] dest;      // bits 10:6
        logic [REG_IDX_W-1:0] arg;       // bits 5:1
        logic                 sub_sel;   // bit 0
    } vl_field_t;

    typedef enum logic [2:0] {
        MODE_KEEP,
        MODE_LOOP_IMM,
        MODE_LOOP_REG,
        MODE_ONEOFF,
        MODE_MAX_ONLY
    } vl_mode_e;

    typedef struct packed {
        vl_mode_e             mode;
        logic                 bad;
        logic [REG_IDX_W-1:0] dest;
        logic [REG_IDX_W-1:0] arg;
    } vl_dec_t;

    function automatic vl_mode_e classify(input vl_field_t f);
        vl_mode_e m;
        if (f == '0)
            m = MODE_KEEP;
        else begin
            unique case ({f.one_off, f.sub_sel})
                2'b00:   m = MODE_LOOP_IMM;
                2'b01:   m = MODE_LOOP_REG;
                2'b10:   m = MODE_ONEOFF;
                default: m = MODE_MAX_ONLY;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
    import vlcfg_pkg::*;
(
    input  logic [FIELD_W-1:0]   field,
    input  logic                 opt_en,
    output vl_dec_t              dec,
    output logic [REG_IDX_W-1:0] rd_addr
);
    vl_field_t f;
    vl_mode_e  m;

    assign f = vl_field_t'(field);
    assign m = classify(f);

    always_comb begin
        dec.mode = m;
        dec.dest = f.dest;
        dec.arg  = f.arg;
        dec.bad  = ((m != MODE_KEEP) && !opt_en) ||
                   ((m == MODE_LOOP_REG) && (f.arg == '0));
    end

    assign rd_addr = f.arg;

endmodule

// File: rtl/vlcfg_len_calc.sv
module vlcfg_len_calc
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  vl_dec_t          dec,
    input  logic [XLEN-1:0]  rdata,
    input  logic [LEN_W-1:0] max_now,
    input  logic [LEN_W-1:0] cur_now,
    output logic [LEN_W-1:0] max_nxt,
    output logic [LEN_W-1:0] cur_nxt
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic [LEN_W-1:0] imm_len;
    logic [LEN_W-1:0] reg_len;

    assign imm_len = {{(LEN_W-REG_IDX_W){1'b0}}, dec.arg} + ONE;

    function automatic logic [LEN_W-1:0] min_of(input logic [LEN_W-1:0] a,
                                                input logic [LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    generate
        if (XLEN > LEN_W) begin : g_wide
            logic [XLEN-1:0] max_ext;
            assign max_ext = {{(XLEN-LEN_W){1'b0}}, max_now};
            always_comb begin
                if (rdata == '0)
                    reg_len = ONE;
                else if (rdata > max_ext)
                    reg_len = max_now;
                else
                    reg_len = rdata[LEN_W-1:0];
            end
        end else begin : g_same
            always_comb begin
                if (rdata == '0)
                    reg_len = ONE;
                else
                    reg_len = min_of(rdata[LEN_W-1:0], max_now);
            end
        end
    endgenerate

    always_comb begin
        max_nxt = max_now;
        cur_nxt = cur_now;
        unique case (dec.mode)
            MODE_LOOP_IMM: cur_nxt = min_of(imm_len, max_now);
            MODE_LOOP_REG: cur_nxt = reg_len;
            MODE_ONEOFF: begin
                max_nxt = imm_len;
                cur_nxt = imm_len;
            end
            MODE_MAX_ONLY: begin
                max_nxt = imm_len;
                cur_nxt = min_of(cur_now, imm_len);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vlcfg_state.sv
module vlcfg_state
    import vlcfg_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 valid,
    input  vl_dec_t              dec,
    input  logic [LEN_W-1:0]     max_nxt,
    input  logic [LEN_W-1:0]     cur_nxt,
    output logic [LEN_W-1:0]     max_q,
    output logic [LEN_W-1:0]     cur_q,
    output logic                 wb_valid_q,
    output logic [REG_IDX_W-1:0] wb_idx_q,
    output logic [LEN_W-1:0]     wb_data_q,
    output logic                 illegal_q
);
    logic commit;
    logic send_wb;

    assign commit  = valid && !dec.bad && (dec.mode != MODE_KEEP);
    assign send_wb = commit && (dec.dest != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            max_q      <= LEN_W'(1);
            cur_q      <= LEN_W'(1);
            wb_valid_q <= 1'b0;
            wb_idx_q   <= '0;
            wb_data_q  <= '0;
            illegal_q  <= 1'b0;
        end else begin
            if (commit) begin
                max_q <= max_nxt;
                cur_q <= cur_nxt;
            end
            wb_valid_q <= send_wb;
            illegal_q  <= valid && dec.bad;
            if (send_wb) begin
                wb_idx_q  <= dec.dest;
                wb_data_q <= cur_nxt;
            end
        end
    end

    // R11: ordering of the two lengths
    a_r11_len_bounds: assert property (@(posedge clk) disable iff (rst)
        (cur_q >= LEN_W'(1)) && (cur_q <= max_q));

    // R2: zero field leaves everything alone
    a_r2_keep_stable: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.mode == MODE_KEEP) |=> ($stable(max_q) && $stable(cur_q) && !wb_valid_q && !illegal_q));

    // R5/R9: illegal pulse means no state change at that edge
    a_r9_illegal_hold: assert property (@(posedge clk) disable iff (rst)
        illegal_q |-> (max_q == $past(max_q)) && (cur_q == $past(cur_q)));

    // R3: loop mode keeps the maximum
    a_r3_loop_keeps_max: assert property (@(posedge clk) disable iff (rst)
        (valid && !dec.bad && (dec.mode == MODE_LOOP_IMM || dec.mode == MODE_LOOP_REG)) |=> $stable(max_q));

    // R6: one-off setting makes both limits equal
    a_r6_oneoff_equal: assert property (@(posedge clk) disable iff (rst)
        (valid && !dec.bad && dec.mode == MODE_ONEOFF) |=> (max_q == cur_q));

    // R7: max-only mode never raises the current length
    a_r7_no_growth: assert property (@(posedge clk) disable iff (rst)
        (valid && !dec.bad && dec.mode == MODE_MAX_ONLY) |=> (cur_q <= $past(cur_q)));

    // R8: no write-back to x0, and write-back mirrors the stored length
    a_r8_wb_not_x0: assert property (@(posedge clk) disable iff (rst)
        wb_valid_q |-> (wb_idx_q != '0) && (wb_data_q == cur_q));

    // R10: write-back and illegal are mutually exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid_q && illegal_q));

endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
    import vlcfg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_valid,
    input  logic [FIELD_W-1:0]   cfg_field,
    input  logic                 opt_en,
    output logic [REG_IDX_W-1:0] rs_idx,
    input  logic [XLEN-1:0]      rs_rdata,
    output logic [LEN_W-1:0]     max_len,
    output logic [LEN_W-1:0]     cur_len,
    output logic                 wb_valid,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [LEN_W-1:0]     wb_data,
    output logic                 illegal
);
    vl_dec_t          dec;
    logic [LEN_W-1:0] max_nxt;
    logic [LEN_W-1:0] cur_nxt;

    vlcfg_decode u_decode (
        .field   (cfg_field),
        .opt_en  (opt_en),
        .dec     (dec),
        .rd_addr (rs_idx)
    );

    vlcfg_len_calc #(.XLEN(XLEN), .LEN_W(LEN_W)) u_calc (
        .dec     (dec),
        .rdata   (rs_rdata),
        .max_now (max_len),
        .cur_now (cur_len),
        .max_nxt (max_nxt),
        .cur_nxt (cur_nxt)
    );

    vlcfg_state #(.LEN_W(LEN_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .valid      (cfg_valid),
        .dec        (dec),
        .max_nxt    (max_nxt),
        .cur_nxt    (cur_nxt),
        .max_q      (max_len),
        .cur_q      (cur_len),
        .wb_valid_q (wb_valid),
        .wb_idx_q   (wb_idx),
        .wb_data_q  (wb_data),
        .illegal_q  (illegal)
    );

endmodule

// File: tb/test_vlcfg_unit.sv
module test_vlcfg_unit;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN  = 64;
    localparam int LEN_W = 7;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_valid = 1'b0;
    logic [11:0]      cfg_field = '0;
    logic             opt_en = 1'b1;
    logic [4:0]       rs_idx;
    logic [XLEN-1:0]  rs_rdata = '0;
    logic [LEN_W-1:0] max_len, cur_len, wb_data;
    logic             wb_valid, illegal;
    logic [4:0]       wb_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int m_max = 1;
    int m_cur = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlcfg_unit #(.XLEN(XLEN), .LEN_W(LEN_W)) i_vlcfg_unit (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_field(cfg_field),
        .opt_en(opt_en), .rs_idx(rs_idx), .rs_rdata(rs_rdata),
        .max_len(max_len), .cur_len(cur_len), .wb_valid(wb_valid),
        .wb_idx(wb_idx), .wb_data(wb_data), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input bit hi, input int dest, input int arg, input bit lo);
        return {hi, 5'(dest), 5'(arg), lo};
    endfunction

    // Drive one strobed field and check the response one edge later.
    task automatic do_op(input logic [11:0] f, input logic [63:0] rd, input bit opt, input string req);
        bit ill;
        bit wbe;
        int e_max, e_cur, imm;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_field = f; rs_rdata = rd; opt_en = opt;
        #1;
        if (f[11] == 1'b0 && f[0] == 1'b1)
            check(rs_idx == f[5:1], "R4 read address", rs_idx, f[5:1]);
        imm   = int'(f[5:1]) + 1;
        ill   = (f != 0) && (!opt || (f[11] == 1'b0 && f[0] == 1'b1 && f[5:1] == 0));
        e_max = m_max; e_cur = m_cur;
        if (!ill && f != 0) begin
            case ({f[11], f[0]})
                2'b00: e_cur = (imm < m_max) ? imm : m_max;
                2'b01: e_cur = (rd == 0) ? 1 : ((rd > 64'(m_max)) ? m_max : int'(rd));
                2'b10: begin e_max = imm; e_cur = imm; end
                default: begin e_max = imm; e_cur = (m_cur < imm) ? m_cur : imm; end
            endcase
        end
        wbe = !ill && (f != 0) && (f[10:6] != 0);
        @(negedge clk);
        cfg_valid = 1'b0;
        check(max_len == e_max, {req, " max"}, max_len, e_max);
        check(cur_len == e_cur, {req, " cur"}, cur_len, e_cur);
        check(illegal == ill, {req, " illegal"}, illegal, ill);
        check(wb_valid == wbe, {req, " R8 wb_valid"}, wb_valid, wbe);
        if (wbe) begin
            check(wb_idx == f[10:6], {req, " R8 wb_idx"}, wb_idx, f[10:6]);
            check(wb_data == e_cur, {req, " R8 wb_data"}, wb_data, e_cur);
        end
        @(negedge clk);
        check(!wb_valid && !illegal, "R10 pulse width", {wb_valid, illegal}, 0);
        check((cur_len >= 1) && (cur_len <= max_len), "R11 bounds", cur_len, max_len);
        m_max = e_max; m_cur = e_cur;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(max_len == 1 && cur_len == 1, "R1 reset lengths", max_len, 1);
        check(!wb_valid && !illegal, "R1 reset strobes", {wb_valid, illegal}, 0);

        // R2: zero field, both option settings
        do_op(12'h000, 64'd9, 1'b1, "R2 zero opt1");
        do_op(12'h000, 64'd9, 1'b0, "R2 zero opt0");

        // R6: one-off sweep over every immediate, destinations incl. 0
        for (int i = 0; i < 32; i++)
            do_op(mk(1, (i * 7) % 32, i, 0), 64'd0, 1'b1, "R6 oneoff");

        // R7: shrink step by step from 32 down to 1, then grow again
        do_op(mk(1, 4, 31, 0), 64'd0, 1'b1, "R6 setup");
        for (int i = 31; i >= 0; i--)
            do_op(mk(1, i % 3, i, 1), 64'd0, 1'b1, "R7 shrink");
        for (int i = 0; i < 32; i += 5)
            do_op(mk(1, 2, i, 1), 64'd0, 1'b1, "R7 grow");

        // R3: loop immediate across every immediate under several maxima
        for (int mx = 0; mx < 32; mx += 10) begin
            do_op(mk(1, 0, mx, 0), 64'd0, 1'b1, "R6 setup");
            for (int i = 0; i < 32; i++)
                do_op(mk(0, (i % 2) ? 0 : 3, i, 0), 64'd0, 1'b1, "R3 loop imm");
        end

        // R4: loop register source under max 20
        do_op(mk(1, 0, 19, 0), 64'd0, 1'b1, "R6 setup");
        begin
            logic [63:0] vals [8] = '{64'd0, 64'd1, 64'd5, 64'd19, 64'd20,
                                      64'd21, 64'd128, 64'hFFFF_0000_0000_0003};
            foreach (vals[k])
                do_op(mk(0, k + 1, k + 2, 1), vals[k], 1'b1, "R4 loop reg");
        end
        do_op(mk(0, 0, 9, 1), 64'd7, 1'b1, "R4 loop reg no dest");

        // R5: x0 as length source
        do_op(mk(0, 6, 0, 1), 64'd3, 1'b1, "R5 x0 source");
        do_op(mk(0, 0, 0, 1), 64'd3, 1'b1, "R5 x0 source no dest");

        // R9: option disabled, each mode
        do_op(mk(0, 5, 3, 0), 64'd0, 1'b0, "R9 opt off loop imm");
        do_op(mk(0, 5, 3, 1), 64'd2, 1'b0, "R9 opt off loop reg");
        do_op(mk(1, 5, 3, 0), 64'd0, 1'b0, "R9 opt off oneoff");
        do_op(mk(1, 5, 0, 1), 64'd0, 1'b0, "R9 opt off max only");
        do_op(mk(0, 1, 0, 0), 64'd0, 1'b0, "R9 opt off tiny");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule